// File: doc/BRIEF.md
# Sixteen-Channel Vectored Interrupt Controller

The block gathers sixteen single-cycle event strobes into one interrupt request line. Each channel has four state bits: enable, pending, mask and in-service. It picks the highest-numbered channel that may request and, on a synchronous acknowledge strobe, answers with an 8-bit vector. The vector's upper nibble comes from a programmable base and its lower nibble is the winning channel number.

Software reaches the state through byte-wide registers. Pending and in-service bits can only be cleared, by writing zeros. A mode bit chooses between two ways of ending an interrupt. In automatic mode, history ends at the acknowledge. In software mode, an in-service bit holds off the channel and every channel below it until software clears that bit.

Several controllers can share one acknowledge through a priority-in / priority-out daisy chain. Any acknowledge that this block does not consume is passed downstream.

Top module: `vic_top`

## Requirements
- R1: After reset every register (enable, pending, in-service, mask, vector) reads 0, `irq_o` is low and `pri_out_no` is high.
- R2: Channel 15 has the highest priority and channel 0 the lowest. On a granted acknowledge, `vec_o` = {vector base bits 7:4, 4-bit number of the highest requesting channel}. Otherwise `vec_o` is 0.
- R3: Register map on `addr_i`: 0/1 enable high/low byte, 2/3 pending, 4/5 in-service, 6/7 mask, 8 vector register (bits 7:4 base, bit 3 mode, bits 2:0 read 0). All other addresses read 0. A high byte holds channels 15..8 and a low byte holds channels 7..0, with bit 7 being the larger channel number. `rdata_o` is combinational from the address.
- R4: A disabled channel ignores events. Its pending bit is 0 from the cycle after its enable bit becomes 0. Disabling leaves its in-service bit unchanged.
- R5: Writing 0 to a pending or in-service bit clears it, and writing 1 leaves it unchanged. Software can never set an in-service bit.
- R6: A mask bit of 0 lets the pending bit latch but removes the channel's request. Setting the mask back to 1 restores the request while the bit is still pending.
- R7: With mode bit 0 (automatic), a granted acknowledge clears the winner's pending bit, and all in-service bits stay 0.
- R8: With mode bit 1 (software), a granted acknowledge clears the winner's pending bit and sets its in-service bit.
- R9: A set in-service bit blocks requests and acknowledges from its own channel and from every lower channel. Pending bits still latch, and higher channels still request and are acknowledged.
- R10: An acknowledge is granted only when `ack_ni` is low, `pri_in_ni` is low and some channel requests. A grant raises `vec_valid_o` and keeps `pri_out_no` high. With no request, `pri_out_no` goes low and no vector is given. With `ack_ni` or `pri_in_ni` high, `pri_out_no` is high, nothing is granted and no state changes.
- R11: An event on an enabled channel sets its pending bit even when a software clear or a granted acknowledge of that bit falls in the same cycle.
- R12: `irq_o` is high exactly when some channel is enabled, pending and unmasked, with no in-service bit set at its own or a higher channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Single-cycle event strobes, one per channel |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request, active high |
| ack_ni | input | 1 | Acknowledge strobe, active low |
| pri_in_ni | input | 1 | Daisy-chain priority in, active low |
| pri_out_no | output | 1 | Daisy-chain priority out, active low |
| vec_o | output | 8 | Acknowledge vector |
| vec_valid_o | output | 1 | Vector granted this cycle |

## Verification
Directed sequences pit two simultaneous events against each other to prove the winner is the higher channel. They also nest a higher event under an in-service channel, re-raise an event on a channel that is already in service, and mask and unmask a pending channel. Further directed cases collide an event with a clear or an acknowledge, and acknowledge with the chain input high or with nothing pending. These separate blocking from masking, and the downstream-pass case from the hold case. Long random runs then mix sparse event bursts, random register writes (which also flip the mode and enables), and random acknowledge and chain inputs. Every cycle of those runs is compared against a bench model, which exposes wrong orderings between disable, event, clear and acknowledge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int CH_N   = 16;
  localparam int CH_W   = $clog2(CH_N);
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int VB_W   = 4;
  localparam int MODE_BIT = 3;

  localparam logic [ADDR_W-1:0] A_EN_HI   = 4'd0;
  localparam logic [ADDR_W-1:0] A_EN_LO   = 4'd1;
  localparam logic [ADDR_W-1:0] A_PEND_HI = 4'd2;
  localparam logic [ADDR_W-1:0] A_PEND_LO = 4'd3;
  localparam logic [ADDR_W-1:0] A_ISR_HI  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ISR_LO  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MASK_HI = 4'd6;
  localparam logic [ADDR_W-1:0] A_MASK_LO = 4'd7;
  localparam logic [ADDR_W-1:0] A_VEC     = 4'd8;
endpackage

// File: rtl/vic_chan.sv
module vic_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic en_we_i,
  input  logic en_d_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  input  logic pend_clr_i,
  input  logic isr_clr_i,
  input  logic take_i,
  input  logic soft_i,
  output logic en_o,
  output logic mask_o,
  output logic pend_o,
  output logic isr_o
);
  logic en_q, mask_q, pend_q, isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      pend_q <= 1'b0;
      isr_q  <= 1'b0;
    end else begin
      if (en_we_i)   en_q   <= en_d_i;
      if (mask_we_i) mask_q <= mask_d_i;
      // disable dominates, then event beats any clear
      if (!en_q)                      pend_q <= 1'b0;
      else if (evt_i)                 pend_q <= 1'b1;
      else if (take_i || pend_clr_i)  pend_q <= 1'b0;
      // automatic mode holds in-service in reset; grant beats a clear
      if (!soft_i)         isr_q <= 1'b0;
      else if (take_i)     isr_q <= 1'b1;
      else if (isr_clr_i)  isr_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign isr_o  = isr_q;

  a_r4_disabled_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !pend_q);
  a_r11_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && evt_i) |=> pend_q);
  a_r5_isr_only_by_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isr_q) |-> $past(take_i));
  a_r7_auto_no_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_i |=> !isr_q);
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_N-1:0] en_i,
  input  logic [CH_N-1:0] mask_i,
  input  logic [CH_N-1:0] pend_i,
  input  logic [CH_N-1:0] isr_i,
  output logic [CH_N-1:0] req_o,
  output logic            irq_o,
  output logic            win_any_o,
  output logic [CH_W-1:0] win_id_o
);
  logic [CH_N-1:0] blocked;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = CH_N-1; i >= 0; i--) begin
      acc = acc | isr_i[i];
      blocked[i] = acc;
    end
  end

  assign req_o     = en_i & mask_i & pend_i & ~blocked;
  assign irq_o     = |req_o;
  assign win_any_o = |req_o;

  always_comb begin
    win_id_o = '0;
    for (int i = 0; i < CH_N; i++)
      if (req_o[i]) win_id_o = CH_W'(i);
  end

  a_r2_winner_highest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_any_o |-> ((req_o >> win_id_o) == CH_N'(1)));
  a_r9_winner_unblocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_any_o |-> ((isr_i >> win_id_o) == '0));
  a_r12_irq_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($countones(en_i & pend_i & mask_i) > 0));
endmodule

// File: rtl/vic_ack.sv
module vic_ack
  import vic_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ack_ni,
  input  logic            pri_in_ni,
  input  logic            win_any_i,
  input  logic [CH_W-1:0] win_id_i,
  input  logic [VB_W-1:0] vbase_i,
  output logic [7:0]      vec_o,
  output logic            vec_valid_o,
  output logic            pri_out_no,
  output logic            take_o
);
  logic sel;

  assign sel         = !ack_ni && !pri_in_ni;
  assign take_o      = sel && win_any_i;
  assign vec_valid_o = take_o;
  assign pri_out_no  = !(sel && !win_any_i);
  assign vec_o       = take_o ? {vbase_i, win_id_i} : 8'h00;

  a_r10_chain_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> pri_out_no);
  a_r10_idle_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ni || pri_in_ni) |-> (pri_out_no && !vec_valid_o));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH_N-1:0]   evt_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              ack_ni,
  input  logic              pri_in_ni,
  output logic              pri_out_no,
  output logic [7:0]        vec_o,
  output logic              vec_valid_o
);
  logic [CH_N-1:0] en_q, mask_q, pend_q, isr_q, req;
  logic [VB_W-1:0] vbase_q;
  logic            soft_q;
  logic            win_any, take;
  logic [CH_W-1:0] win_id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbase_q <= '0;
      soft_q  <= 1'b0;
    end else if (we_i && addr_i == A_VEC) begin
      vbase_q <= wdata_i[BYTE_W-1 -: VB_W];
      soft_q  <= wdata_i[MODE_BIT];
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    localparam int  BIT = c % BYTE_W;
    localparam bit  HI  = (c >= BYTE_W);
    localparam logic [ADDR_W-1:0] EN_A   = HI ? A_EN_HI   : A_EN_LO;
    localparam logic [ADDR_W-1:0] MASK_A = HI ? A_MASK_HI : A_MASK_LO;
    localparam logic [ADDR_W-1:0] PEND_A = HI ? A_PEND_HI : A_PEND_LO;
    localparam logic [ADDR_W-1:0] ISR_A  = HI ? A_ISR_HI  : A_ISR_LO;
    vic_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[c]),
      .en_we_i    (we_i && addr_i == EN_A),
      .en_d_i     (wdata_i[BIT]),
      .mask_we_i  (we_i && addr_i == MASK_A),
      .mask_d_i   (wdata_i[BIT]),
      .pend_clr_i (we_i && addr_i == PEND_A && !wdata_i[BIT]),
      .isr_clr_i  (we_i && addr_i == ISR_A && !wdata_i[BIT]),
      .take_i     (take && win_id == CH_W'(c)),
      .soft_i     (soft_q),
      .en_o       (en_q[c]),
      .mask_o     (mask_q[c]),
      .pend_o     (pend_q[c]),
      .isr_o      (isr_q[c])
    );
  end

  vic_prio u_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .mask_i    (mask_q),
    .pend_i    (pend_q),
    .isr_i     (isr_q),
    .req_o     (req),
    .irq_o     (irq_o),
    .win_any_o (win_any),
    .win_id_o  (win_id)
  );

  vic_ack u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_ni      (ack_ni),
    .pri_in_ni   (pri_in_ni),
    .win_any_i   (win_any),
    .win_id_i    (win_id),
    .vbase_i     (vbase_q),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .pri_out_no  (pri_out_no),
    .take_o      (take)
  );

  always_comb begin
    unique case (addr_i)
      A_EN_HI:   rdata_o = en_q[CH_N-1:BYTE_W];
      A_EN_LO:   rdata_o = en_q[BYTE_W-1:0];
      A_PEND_HI: rdata_o = pend_q[CH_N-1:BYTE_W];
      A_PEND_LO: rdata_o = pend_q[BYTE_W-1:0];
      A_ISR_HI:  rdata_o = isr_q[CH_N-1:BYTE_W];
      A_ISR_LO:  rdata_o = isr_q[BYTE_W-1:0];
      A_MASK_HI: rdata_o = mask_q[CH_N-1:BYTE_W];
      A_MASK_LO: rdata_o = mask_q[BYTE_W-1:0];
      A_VEC:     rdata_o = {vbase_q, soft_q, 3'b000};
      default:   rdata_o = '0;
    endcase
  end

  a_r8_grant_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && soft_q) |=> isr_q[$past(vec_o[CH_W-1:0])]);
  a_r2_vector_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o[7:4] == vbase_q && irq_o));
endmodule

// File: tb/vic_top_tb_top.sv
`timescale 1ns/1ps
module vic_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic        ack_n = 1'b1;
  logic        pin_n = 1'b1;
  logic        pri_out_n;
  logic [7:0]  vec;
  logic        vv;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_en = '0, m_pend = '0, m_isr = '0, m_mask = '0;
  logic [7:0]  m_vr = '0;
  logic [7:0]  l_rdata, l_vec;
  logic        l_irq, l_vv, l_po;

  always #10 clk = ~clk;

  vic_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .ack_ni(ack_n),
    .pri_in_ni(pin_n), .pri_out_no(pri_out_n), .vec_o(vec), .vec_valid_o(vv)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_req();
    logic b = 1'b0;
    logic [15:0] r;
    for (int i = 15; i >= 0; i--) begin
      b = b | m_isr[i];
      r[i] = m_en[i] & m_pend[i] & m_mask[i] & !b;
    end
    return r;
  endfunction

  function automatic logic [3:0] m_win(input logic [15:0] r);
    logic [3:0] id = '0;
    for (int i = 0; i < 16; i++) if (r[i]) id = 4'(i);
    return id;
  endfunction

  function automatic logic [7:0] m_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_en[15:8];
      4'd1: return m_en[7:0];
      4'd2: return m_pend[15:8];
      4'd3: return m_pend[7:0];
      4'd4: return m_isr[15:8];
      4'd5: return m_isr[7:0];
      4'd6: return m_mask[15:8];
      4'd7: return m_mask[7:0];
      4'd8: return m_vr;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cyc(input logic [15:0] e, input logic w, input logic [3:0] a,
                     input logic [7:0] d, input logic ak, input logic pi);
    logic [15:0] rq, np, ni;
    logic any, take, pc, ic, tk;
    logic [3:0] id;
    @(negedge clk);
    evt = e; we = w; addr = a; wdata = d; ack_n = ak; pin_n = pi;
    #2;
    rq = m_req(); any = |rq; id = m_win(rq);
    take = !ak && !pi && any;
    chk("R12 irq", 16'(irq), 16'(any));
    chk("R10 pri_out", 16'(pri_out_n), 16'(!(!ak && !pi && !any)));
    chk("R10 vec_valid", 16'(vv), 16'(take));
    chk("R2 vector", 16'(vec), 16'(take ? {m_vr[7:4], id} : 8'h00));
    chk("R3 readback", 16'(rdata), 16'(m_rd(a)));
    l_rdata = rdata; l_vec = vec; l_irq = irq; l_vv = vv; l_po = pri_out_n;
    @(posedge clk);
    #1;
    for (int i = 0; i < 16; i++) begin
      pc = w && a == ((i >= 8) ? 4'd2 : 4'd3) && !d[i % 8];
      ic = w && a == ((i >= 8) ? 4'd4 : 4'd5) && !d[i % 8];
      tk = take && id == 4'(i);
      np[i] = !m_en[i] ? 1'b0 : e[i] ? 1'b1 : (tk || pc) ? 1'b0 : m_pend[i];
      ni[i] = !m_vr[3] ? 1'b0 : tk ? 1'b1 : ic ? 1'b0 : m_isr[i];
    end
    m_pend = np; m_isr = ni;
    if (w) case (a)
      4'd0: m_en[15:8]   = d;
      4'd1: m_en[7:0]    = d;
      4'd6: m_mask[15:8] = d;
      4'd7: m_mask[7:0]  = d;
      4'd8: m_vr = {d[7:3], 3'b000};
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a);
    cyc(16'h0, 1'b0, a, 8'h00, 1'b1, 1'b1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(16'h0, 1'b1, a, d, 1'b1, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a));
      chk("R1 reset reg", 16'(l_rdata), 16'h0);
      chk("R1 reset irq", 16'(l_irq), 16'h0);
      chk("R1 reset chain", 16'(l_po), 16'h1);
    end

    wr(0, 8'hFF); wr(1, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF); wr(8, 8'h48);
    cyc(16'h1008, 0, 2, 0, 1, 1);
    rd(2);
    chk("R3 pending high byte", 16'(l_rdata), 16'h10);
    chk("R12 irq raised", 16'(l_irq), 16'h1);
    cyc(0, 0, 4, 0, 0, 0);
    chk("R2 ch12 beats ch3", 16'(l_vec), 16'h4C);
    rd(4);
    chk("R8 isr set", 16'(l_rdata), 16'h10);
    chk("R9 lower blocked", 16'(l_irq), 16'h0);
    rd(2);
    chk("R8 pending cleared", 16'(l_rdata), 16'h00);
    cyc(16'h2000, 0, 2, 0, 1, 1);
    cyc(0, 0, 4, 0, 0, 0);
    chk("R9 higher acked", 16'(l_vec), 16'h4D);
    wr(4, 8'hDF); rd(4);
    chk("R5 isr write zero", 16'(l_rdata), 16'h10);
    wr(4, 8'hFF); rd(4);
    chk("R5 ones no effect", 16'(l_rdata), 16'h10);
    wr(5, 8'hFF); rd(5);
    chk("R5 isr not settable", 16'(l_rdata), 16'h00);
    cyc(16'h1000, 0, 2, 0, 1, 1); rd(2);
    chk("R9 same channel latches", 16'(l_rdata), 16'h10);
    chk("R9 same channel held", 16'(l_irq), 16'h0);
    wr(4, 8'hEF); rd(4);
    chk("R9 released request", 16'(l_irq), 16'h1);
    wr(2, 8'hEF); rd(2);
    chk("R5 pending write zero", 16'(l_rdata), 16'h00);
    cyc(0, 0, 3, 0, 0, 1);
    chk("R10 upstream holds valid", 16'(l_vv), 16'h0);
    chk("R10 upstream holds chain", 16'(l_po), 16'h1);
    rd(3);
    chk("R10 no state change", 16'(l_rdata), 16'h08);
    wr(7, 8'hF7); rd(3);
    chk("R6 masked no irq", 16'(l_irq), 16'h0);
    chk("R6 pending kept", 16'(l_rdata), 16'h08);
    wr(7, 8'hFF); rd(3);
    chk("R6 unmask resumes", 16'(l_irq), 16'h1);
    wr(8, 8'h40);
    cyc(0, 0, 4, 0, 0, 0);
    chk("R7 vector", 16'(l_vec), 16'h43);
    rd(5);
    chk("R7 no isr", 16'(l_rdata), 16'h00);
    rd(3);
    chk("R7 pending cleared", 16'(l_rdata), 16'h00);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R10 empty passes chain", 16'(l_po), 16'h0);
    chk("R10 empty no vector", 16'(l_vv), 16'h0);
    cyc(16'h0008, 0, 3, 0, 1, 1);
    wr(1, 8'hF7); rd(3); rd(3);
    chk("R4 pending dropped", 16'(l_rdata), 16'h00);
    cyc(16'h0008, 0, 3, 0, 1, 1); rd(3);
    chk("R4 event ignored", 16'(l_rdata), 16'h00);
    wr(1, 8'hFF);
    wr(8, 8'h48);
    cyc(16'h1000, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0);
    wr(0, 8'hEF); rd(4); rd(4);
    chk("R4 isr kept", 16'(l_rdata), 16'h10);
    wr(4, 8'h00); wr(0, 8'hFF);
    cyc(16'h0004, 1, 3, 8'h00, 1, 1); rd(3);
    chk("R11 event beats clear", 16'(l_rdata), 16'h04);
    cyc(16'h0004, 0, 3, 0, 0, 0);
    chk("R2 vector ch2", 16'(l_vec), 16'h42);
    rd(3);
    chk("R11 event beats ack", 16'(l_rdata), 16'h04);
    rd(5);
    chk("R8 isr low byte", 16'(l_rdata), 16'h04);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] e;
      e = (($urandom % 4) == 0) ? 16'($urandom & $urandom) : 16'h0;
      cyc(e, ($urandom % 4) == 0, 4'($urandom % 10), 8'($urandom),
          ($urandom % 3) != 0, ($urandom % 4) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule